// File: doc/BRIEF.md
# Monitor Word Serial Burst Transmitter

This block sends a fixed burst of four 32-bit monitor words out of a single serial data pin. A companion bit clock goes with the data. A one-cycle start strobe, issued at the beginning of the settle state of each sampling frame, copies the four parallel input words into a shadow register. The block then sends them as one burst of 140 fast-clock cycles. Each word occupies a slot of 35 cycles: its 32 data bits most significant bit first, then a flag slot, then a status slot that repeats the word's sign bit, then a trailing marker slot. The trailing slot is an ignore slot for words 0 to 2 and carries the last-word marker for word 3. The fixed length lets the burst finish before the next compute pass begins.

The block is driven by a finite-state machine with five named states. ST_IDLE waits for the strobe. ST_DATA sends the 32 data bits of the current word. ST_FLAG, ST_STAT and ST_TAIL send the three marker slots. The transitions are:
- start: ST_IDLE to ST_DATA when the strobe is sampled.
- word_done: ST_DATA to ST_FLAG after data bit 31.
- flag_done: ST_FLAG to ST_STAT.
- stat_done: ST_STAT to ST_TAIL.
- next_word: ST_TAIL to ST_DATA while words remain.
- burst_done: ST_TAIL to ST_IDLE after word 3.

One serial bit is sent per fast-clock cycle. Serial data changes on the rising fast-clock edge, which is the falling edge of the bit clock. The data is therefore stable when the bit clock rises.

Top module: `rtm_serializer`

## Requirements
- R1: While reset is asserted, and directly after it is released, busy_o, sync_o, ser_data_o and ser_clk_o are all 0.
- R2: A burst sends words 0, 1, 2 and 3 in that order. Word i is words_i[32*i+31:32*i]. Each word takes burst cycles 35*i to 35*i+31, with bit 31 sent first.
- R3: Burst cycle 35*i+32 (the flag slot) carries 1. Burst cycle 35*i+33 (the status slot) carries bit 31 of word i.
- R4: Burst cycle 35*i+34 (the trailing slot) carries 1 for word 3 only and 0 for words 0 to 2.
- R5: busy_o rises on the clock edge that samples start_i high in the idle state. It stays high for exactly 140 cycles and then falls.
- R6: A start strobe that arrives while busy_o is high is ignored. It neither restarts nor lengthens the burst, and it does not start a second burst.
- R7: The words are captured when the strobe is accepted. Changes on words_i during a burst have no effect on the serial data.
- R8: sync_o is high only in burst cycle 0, the first data bit of word 0.
- R9: ser_clk_o is 0 when idle. During a burst it is the inverse of clk, so it is high while clk is low and low while clk is high.
- R10: ser_data_o is 0 whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst start strobe, issued at the settle state |
| words_i | input | 128 | Four monitor words; word i in bits 32*i+31 to 32*i |
| ser_data_o | output | 1 | Serial data |
| ser_clk_o | output | 1 | Serial bit clock, inverse of clk while busy |
| sync_o | output | 1 | High for the first burst cycle |
| busy_o | output | 1 | High for the 140 cycles of a burst |

## Verification
The assertions assume that the strobe and words_i are driven synchronously to clk, with changes made away from the rising edge. This matters most for ser_clk_o: it is derived from the clock level, so the check on it compares values sampled just before each rising edge. The assertions also assume that reset is held long enough to bring the state machine to ST_IDLE. The bench meets these assumptions by changing every input on the falling edge of clk. Its strobes that fall outside a burst are single-cycle pulses, and it only changes words_i or pulses start_i during a burst in order to test R6 and R7.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
    parameter int WORD_W   = 32;
    parameter int N_WORDS  = 4;
    parameter int N_MARK   = 3;
    localparam int SLOT_LEN  = WORD_W + N_MARK;
    localparam int BURST_LEN = SLOT_LEN * N_WORDS;
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int WIDX_W    = $clog2(N_WORDS);
    localparam int ALL_W     = WORD_W * N_WORDS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_FLAG,
        ST_STAT,
        ST_TAIL
    } rtm_state_e;
endpackage

// File: rtl/rtm_shadow.sv
module rtm_shadow
    import rtm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ALL_W-1:0] words_i,
    output logic [ALL_W-1:0] words_o
);
    // One capture register per word; loaded only on an accepted strobe.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] hold_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q <= '0;
            end else if (load_i) begin
                hold_q <= words_i[g*WORD_W +: WORD_W];
            end
        end
        assign words_o[g*WORD_W +: WORD_W] = hold_q;
    end
endmodule

// File: rtl/rtm_seq.sv
module rtm_seq
    import rtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output rtm_state_e        state_o,
    output logic [BIT_W-1:0]  bit_idx_o,
    output logic [WIDX_W-1:0] word_idx_o,
    output logic              load_o,
    output logic              first_o
);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(N_WORDS - 1);

    rtm_state_e        state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic [WIDX_W-1:0] word_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)            state_d = ST_DATA;
            ST_DATA: if (bit_q == LAST_BIT)  state_d = ST_FLAG;
            ST_FLAG:                         state_d = ST_STAT;
            ST_STAT:                         state_d = ST_TAIL;
            ST_TAIL: begin
                if (word_q == LAST_WORD) state_d = ST_IDLE;
                else                     state_d = ST_DATA;
            end
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Bit and word position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            word_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bit_q  <= '0;
                    word_q <= '0;
                end
                ST_DATA: begin
                    if (bit_q == LAST_BIT) bit_q <= '0;
                    else                   bit_q <= bit_q + 1'b1;
                end
                ST_TAIL: begin
                    bit_q <= '0;
                    if (word_q != LAST_WORD) word_q <= word_q + 1'b1;
                end
                default: begin
                    bit_q  <= bit_q;
                    word_q <= word_q;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        load_o  = (state_q == ST_IDLE) && start_i;
        first_o = (state_q == ST_DATA) && (bit_q == '0) && (word_q == '0);
    end

    assign state_o    = state_q;
    assign bit_idx_o  = bit_q;
    assign word_idx_o = word_q;
endmodule

// File: rtl/rtm_bitsel.sv
module rtm_bitsel
    import rtm_pkg::*;
(
    input  rtm_state_e        state_i,
    input  logic [BIT_W-1:0]  bit_idx_i,
    input  logic [WIDX_W-1:0] word_idx_i,
    input  logic [ALL_W-1:0]  words_i,
    output logic              data_o
);
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(N_WORDS - 1);

    logic [WORD_W-1:0] cur_word;
    logic [BIT_W-1:0]  msb_first;

    always_comb begin
        cur_word  = words_i[word_idx_i*WORD_W +: WORD_W];
        msb_first = BIT_W'(WORD_W - 1) - bit_idx_i;
        unique case (state_i)
            ST_IDLE: data_o = 1'b0;
            ST_DATA: data_o = cur_word[msb_first];
            ST_FLAG: data_o = 1'b1;
            ST_STAT: data_o = cur_word[WORD_W-1];
            ST_TAIL: data_o = (word_idx_i == LAST_WORD);
            default: data_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtm_serializer.sv
module rtm_serializer
    import rtm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ALL_W-1:0] words_i,
    output logic             ser_data_o,
    output logic             ser_clk_o,
    output logic             sync_o,
    output logic             busy_o
);
    rtm_state_e        state;
    logic [BIT_W-1:0]  bit_idx;
    logic [WIDX_W-1:0] word_idx;
    logic              load;
    logic              first;
    logic [ALL_W-1:0]  shadow;

    rtm_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .state_o    (state),
        .bit_idx_o  (bit_idx),
        .word_idx_o (word_idx),
        .load_o     (load),
        .first_o    (first)
    );

    rtm_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .words_i (words_i),
        .words_o (shadow)
    );

    rtm_bitsel u_bitsel (
        .state_i    (state),
        .bit_idx_i  (bit_idx),
        .word_idx_i (word_idx),
        .words_i    (shadow),
        .data_o     (ser_data_o)
    );

    assign busy_o    = (state != ST_IDLE);
    assign sync_o    = first;
    assign ser_clk_o = busy_o & ~clk;
endmodule

// File: rtl/rtm_checker.sv
module rtm_checker
    import rtm_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ser_data_o,
    input logic ser_clk_o,
    input logic sync_o,
    input logic busy_o
);
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
        else             busy_cnt <= '0;
    end

    assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_cnt == CNT_W'(BURST_LEN)));

    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_cnt < CNT_W'(BURST_LEN)));

    assert_start_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    assert_busy_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && busy_cnt < CNT_W'(BURST_LEN - 1)) |=> busy_o);

    assert_sync_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> sync_o);

    assert_sync_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (busy_o && busy_cnt == '0));

    assert_idle_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ser_data_o);

    assert_bitclk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_o == busy_o);
endmodule

bind rtm_serializer rtm_checker u_rtm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ser_data_o (ser_data_o),
    .ser_clk_o  (ser_clk_o),
    .sync_o     (sync_o),
    .busy_o     (busy_o)
);

// File: tb/rtm_serializer_bench.sv
`timescale 1ns/100ps
module rtm_serializer_bench;
    localparam int NW    = 4;
    localparam int WW    = 32;
    localparam int SLOT  = 35;
    localparam int BURST = 140;

    localparam logic [127:0] VEC [4] = '{
        128'hDEADBEEF_12345678_80000001_7FFFFFFE,
        128'h00000000_00000000_00000000_00000000,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] words_i = '0;
    logic         ser_data_o, ser_clk_o, sync_o, busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtm_serializer u_rtm_serializer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .words_i    (words_i),
        .ser_data_o (ser_data_o),
        .ser_clk_o  (ser_clk_o),
        .sync_o     (sync_o),
        .busy_o     (busy_o)
    );

    function automatic logic exp_bit(input logic [127:0] w, input int k);
        int wi  = k / SLOT;
        int pos = k % SLOT;
        if (pos < WW)       return w[wi*WW + WW-1 - pos];
        else if (pos == WW) return 1'b1;
        else if (pos == WW+1) return w[wi*WW + WW-1];
        else                return (wi == NW-1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode 0: plain; 1: change inputs mid-burst (R7); 2: strobe mid-burst (R6)
    task automatic run_burst(input logic [127:0] w, input int mode);
        int bad_data = 0, bad_flag = 0, bad_stat = 0, bad_tail = 0;
        int bad_busy = 0, bad_sync = 0, bad_clk = 0;
        @(negedge clk);
        words_i = w;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < BURST; k++) begin
            int pos = k % SLOT;
            if (ser_data_o !== exp_bit(w, k)) begin
                if (pos < WW)         bad_data++;
                else if (pos == WW)   bad_flag++;
                else if (pos == WW+1) bad_stat++;
                else                  bad_tail++;
            end
            if (busy_o !== 1'b1) bad_busy++;
            if (sync_o !== (k == 0)) bad_sync++;
            if (ser_clk_o !== 1'b1) bad_clk++;
            if (mode == 1 && k == 10) words_i = ~w;
            if (mode == 2) start_i = (k == 50 || k == BURST-1);
            @(negedge clk);
        end
        start_i = 1'b0;
        check(mode == 1 ? "R7 shadowed data bits" : "R2 data bits", bad_data, 0);
        check("R3 flag slots", bad_flag, 0);
        check("R3 status slots", bad_stat, 0);
        check("R4 trailing slots", bad_tail, 0);
        check(mode == 2 ? "R6 busy unchanged by strobe" : "R5 busy high 140 cycles", bad_busy, 0);
        check("R8 sync first cycle only", bad_sync, 0);
        check("R9 bit clock high while clk low", bad_clk, 0);
        check("R5 busy low after 140 cycles", busy_o, 0);
        check("R10 data low when idle", ser_data_o, 0);
        if (mode == 2) begin
            repeat (5) @(negedge clk);
            check("R6 no second burst", busy_o, 0);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy_o, 0);
        check("R1 data in reset", ser_data_o, 0);
        check("R1 sync in reset", sync_o, 0);
        check("R1 bit clock in reset", ser_clk_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", busy_o, 0);
        check("R10 data idle after reset", ser_data_o, 0);

        for (int i = 0; i < 4; i++) run_burst(VEC[i], 0);

        run_burst(128'h13579BDF_2468ACE0_FEDCBA98_01234567, 1);
        run_burst(128'h80000000_00000001_80000000_00000001, 2);

        // R9: bit clock low while clk high during a burst
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(posedge clk);
        #1;
        check("R9 bit clock low while clk high", ser_clk_o, 0);
        wait (!busy_o);
        @(negedge clk);
        check("R9 bit clock low when idle", ser_clk_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule